// File: doc/BRIEF.md
# USB Host Frame Timer

This block paces start-of-frame generation in a USB host engine. A 14-bit reload value gives the frame period in full-speed bit clocks, at 12 MHz. Once the run bit is set, a down-counter counts the period. Each time the counter expires, the block raises a one-cycle request to the packet engine and latches a frame event flag. When that flag is enabled, it drives an interrupt line.

Firmware uses the block through a small byte-wide register window. A read of the high register does not return the reload value. It returns the live remaining count divided by 64. Firmware can use this gauge to judge whether a transfer still fits in the current frame.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, `sof_pulse_o` and `irq_o` are low, and the run bit is clear. Reads at 05h, 06h, 0Dh and 0Fh return 00h. A read at 0Eh returns E0h, because the reload resets to 2EE0h, which is 1 ms at 12 MHz.
- R2: While running, `sof_pulse_o` is high for exactly one cycle in every P cycles, where P is the reload value. The counter reloads in the expiry cycle itself, so no clock is lost between frames.
- R3: A write to 05h that sets bit 0 while the block is stopped restarts the count from the full reload. The first pulse appears P cycles after the clock edge that takes the write.
- R4: Clearing bit 0 of 05h freezes the counter. While stopped there are no pulses and no new flag events, and the gauge read at 0Fh does not change.
- R5: Each expiry sets the frame event flag, which reads as bit 5 of 0Dh.
- R6: A write to 0Dh with bit 5 at 1 clears the flag. A write to 0Dh with bit 5 at 0 leaves the flag unchanged.
- R7: If a clear write and an expiry fall in the same cycle, the flag stays set.
- R8: `irq_o` is high exactly when the flag is set and the enable held in bit 5 of 06h is set. Other bits of 06h and 05h are not stored and read as 0.
- R9: A read at 0Fh returns the live count shifted right by 6. The count is loaded with the reload value and drops by one in every running cycle.
- R10: A write to 0Eh sets reload bits 7:0. A write to 0Fh sets reload bits 13:8 from its low 6 data bits. A reload value changed mid-frame takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| sof_pulse_o | output | 1 | One-cycle start-of-frame request |
| irq_o | output | 1 | Frame interrupt request |

## Verification
The hazard is a firmware clear of the frame flag that lands in the same clock as a timer expiry. If the clear won, that frame event would be lost. The bench measures the period and then drives the 0Dh write so that it is sampled on the exact expiry edge. It confirms the collision by seeing `sof_pulse_o` high in the following cycle, and then requires the flag to read back as set. The bench also changes the reload mid-frame to show that the frame in progress completes at its old length.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;

    localparam int DW          = 8;
    localparam int CNT_W       = 14;
    localparam int HI_W        = CNT_W - DW;
    localparam int GAUGE_SHIFT = 6;

    localparam logic [CNT_W-1:0] RELOAD_DEFAULT = 14'h2EE0;

    localparam logic [DW-1:0] ADDR_CTRL = 8'h05;
    localparam logic [DW-1:0] ADDR_IEN  = 8'h06;
    localparam logic [DW-1:0] ADDR_STAT = 8'h0D;
    localparam logic [DW-1:0] ADDR_RLO  = 8'h0E;
    localparam logic [DW-1:0] ADDR_RHI  = 8'h0F;

    localparam int BIT_RUN   = 0;
    localparam int BIT_FRAME = 5;

    typedef struct packed {
        logic             run;
        logic             ien;
        logic [CNT_W-1:0] reload;
    } ft_cfg_t;

    typedef struct packed {
        logic start;
        logic clr;
    } ft_cmd_t;

    function automatic logic [DW-1:0] gauge(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] s;
        s = c >> GAUGE_SHIFT;
        return s[DW-1:0];
    endfunction

endpackage

// File: rtl/ft_regs.sv
module ft_regs
    import frame_timer_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             flag_i,
    output ft_cfg_t          cfg_o,
    output ft_cmd_t          cmd_o,
    output logic [DW-1:0]    rdata_o
);

    ft_cfg_t cfg_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q.run    <= 1'b0;
            cfg_q.ien    <= 1'b0;
            cfg_q.reload <= RELOAD_DEFAULT;
        end else if (wr_en_i) begin
            case (addr_i)
                ADDR_CTRL: cfg_q.run                 <= wdata_i[BIT_RUN];
                ADDR_IEN:  cfg_q.ien                 <= wdata_i[BIT_FRAME];
                ADDR_RLO:  cfg_q.reload[DW-1:0]      <= wdata_i;
                ADDR_RHI:  cfg_q.reload[CNT_W-1:DW]  <= wdata_i[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd_o.start = wr_en_i && (addr_i == ADDR_CTRL) && wdata_i[BIT_RUN] && !cfg_q.run;
        cmd_o.clr   = wr_en_i && (addr_i == ADDR_STAT) && wdata_i[BIT_FRAME];
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: rdata_o[BIT_RUN]   = cfg_q.run;
            ADDR_IEN:  rdata_o[BIT_FRAME] = cfg_q.ien;
            ADDR_STAT: rdata_o[BIT_FRAME] = flag_i;
            ADDR_RLO:  rdata_o            = cfg_q.reload[DW-1:0];
            ADDR_RHI:  rdata_o            = gauge(cnt_i);
            default:   rdata_o            = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    // R3: a start command always leaves the block running
    a_r3_start_sets_run: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_o.start |=> cfg_q.run);

    // R10: low reload byte follows a write to 0Eh
    a_r10_low_reload_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && addr_i == ADDR_RLO) |=> cfg_q.reload[DW-1:0] == $past(wdata_i));

endmodule

// File: rtl/ft_counter.sv
module ft_counter
    import frame_timer_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last     = (cnt_q <= CNT_W'(1));
    assign expire_o = run_i && !start_i && last;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= reload_i;
        end else if (run_i) begin
            cnt_q <= last ? reload_i : cnt_q - CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    // R4: count is frozen while stopped
    a_r4_frozen_when_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_i && !start_i) |=> $stable(cnt_o));

    // R9: count steps down by one per running cycle
    a_r9_counts_down: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_i && !start_i && cnt_o > CNT_W'(1)) |=> cnt_o == $past(cnt_o) - CNT_W'(1));

    // R3: start loads the full reload value
    a_r3_start_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> cnt_o == $past(reload_i));

endmodule

// File: rtl/ft_irq.sv
module ft_irq (
    input  logic clk_i,
    input  logic rst_i,
    input  logic expire_i,
    input  logic clr_i,
    input  logic ien_i,
    output logic flag_o,
    output logic irq_o
);

    logic flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= 1'b0;
        end else if (expire_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & ien_i;

    // R5 and R7: an expiry always leaves the flag set
    a_r5_expiry_sets_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        expire_i |=> flag_o);

    // R6: clearing without a collision drops the flag
    a_r6_clear_drops_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !expire_i) |=> !flag_o);

    // R6: without clear or expiry the flag holds
    a_r6_flag_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && !expire_i) |=> $stable(flag_o));

endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import frame_timer_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          sof_pulse_o,
    output logic          irq_o
);

    ft_cfg_t          cfg;
    ft_cmd_t          cmd;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             flag;
    logic             sof_q;

    ft_regs u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cnt_i   (cnt),
        .flag_i  (flag),
        .cfg_o   (cfg),
        .cmd_o   (cmd),
        .rdata_o (rdata_o)
    );

    ft_counter u_counter (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (cfg.run),
        .start_i  (cmd.start),
        .reload_i (cfg.reload),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    ft_irq u_irq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .expire_i (expire),
        .clr_i    (cmd.clr),
        .ien_i    (cfg.ien),
        .flag_o   (flag),
        .irq_o    (irq_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) sof_q <= 1'b0;
        else       sof_q <= expire;
    end

    assign sof_pulse_o = sof_q;

    // R4: a pulse only follows a running cycle
    a_r4_pulse_needs_run: assert property (@(posedge clk_i) disable iff (rst_i)
        sof_pulse_o |-> $past(cfg.run));

    // R5: every pulse is accompanied by a set flag
    a_r5_pulse_with_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        sof_pulse_o |-> flag);

    // R8: no interrupt without a pending flag
    a_r8_no_irq_without_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        !flag |-> !irq_o);

endmodule

// File: tb/usb_frame_timer_tb_top.sv
`timescale 1ns/1ps
module usb_frame_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sof;
    logic       irq;
    int         cyc = 0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usb_frame_timer dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .sof_pulse_o (sof),
        .irq_o       (irq)
    );

    // {write, addr, wdata, expected read}; run bit stays clear throughout
    localparam int NV = 12;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h0E, 8'h34, 8'h00},
        {1'b0, 8'h0E, 8'h00, 8'h34},
        {1'b1, 8'h0F, 8'hC2, 8'h00},
        {1'b0, 8'h0F, 8'h00, 8'h00},
        {1'b1, 8'h06, 8'h20, 8'h00},
        {1'b0, 8'h06, 8'h00, 8'h20},
        {1'b1, 8'h06, 8'hDF, 8'h00},
        {1'b0, 8'h06, 8'h00, 8'h00},
        {1'b1, 8'h05, 8'hFE, 8'h00},
        {1'b0, 8'h05, 8'h00, 8'h00},
        {1'b0, 8'h0D, 8'h00, 8'h00},
        {1'b0, 8'h07, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_pulse(output int t);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sof && n < 20000);
        t = cyc;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] g1;
        int c0, t, t2, n;
        int rl;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(sof == 1'b0, "R1 sof", sof, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        rd(8'h05, d); check(d == 8'h00, "R1 ctrl", d, 0);
        rd(8'h06, d); check(d == 8'h00, "R1 ien", d, 0);
        rd(8'h0D, d); check(d == 8'h00, "R1 stat", d, 0);
        rd(8'h0F, d); check(d == 8'h00, "R1 gauge", d, 0);
        rd(8'h0E, d); check(d == 8'hE0, "R1 reload low", d, 8'hE0);

        // R8 R10 register table while stopped
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][23:16], d);
                check(d == VEC[i][7:0], "R8 R10 table read", d, VEC[i][7:0]);
            end
        end

        // period 20
        wr(8'h0F, 8'h00);
        wr(8'h0E, 8'd20);
        wr(8'h05, 8'h01);
        c0 = cyc;
        wait_pulse(t);
        check(t - c0 == 20, "R3 first pulse delay", t - c0, 20);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        @(negedge clk);
        check(sof == 1'b0, "R2 single-cycle pulse", sof, 0);
        wait_pulse(t2);
        check(t2 - t == 20, "R2 period", t2 - t, 20);
        rd(8'h0D, d); check(d == 8'h20, "R5 flag set", d, 8'h20);
        wr(8'h06, 8'h20);
        check(irq == 1'b1, "R8 irq enabled", irq, 1);
        wr(8'h0D, 8'hDF);
        rd(8'h0D, d); check(d == 8'h20, "R6 write 0 keeps flag", d, 8'h20);
        wr(8'h0D, 8'h20);
        rd(8'h0D, d); check(d == 8'h00, "R6 write 1 clears", d, 0);
        check(irq == 1'b0, "R8 irq drops", irq, 0);

        // R7 clear on the expiry edge
        wait_pulse(t);
        repeat (19) @(negedge clk);
        wr_en = 1'b1; addr = 8'h0D; wdata = 8'h20;
        @(negedge clk);
        wr_en = 1'b0;
        check(sof == 1'b1, "R7 collision aligned", sof, 1);
        rd(8'h0D, d); check(d == 8'h20, "R7 flag survives clear", d, 8'h20);

        // R10 mid-frame reload change
        wait_pulse(t);
        wr(8'h0E, 8'd10);
        wait_pulse(t2);
        check(t2 - t == 20, "R10 old period completes", t2 - t, 20);
        wait_pulse(t);
        check(t - t2 == 10, "R10 new period", t - t2, 10);

        // R4 stop
        wr(8'h05, 8'h00);
        wr(8'h0D, 8'h20);
        rd(8'h0F, g1);
        n = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sof) n++;
        end
        check(n == 0, "R4 no pulses", n, 0);
        rd(8'h0D, d); check(d == 8'h00, "R4 no flag", d, 0);
        rd(8'h0F, d); check(d == g1, "R4 gauge frozen", d, g1);

        // R3 restart from full reload
        wr(8'h05, 8'h01);
        c0 = cyc;
        wait_pulse(t);
        check(t - c0 == 10, "R3 restart delay", t - c0, 10);

        // R9 gauge with 1 ms reload, high bits masked (R10)
        wr(8'h05, 8'h00);
        wr(8'h0F, 8'hEE);
        wr(8'h0E, 8'hE0);
        rl = 14'h2EE0;
        wr(8'h05, 8'h01);
        c0 = cyc;
        rd(8'h0F, d);
        check(d == 8'((rl - (cyc - c0)) >> 6), "R9 gauge early", d, (rl - (cyc - c0)) >> 6);
        repeat (200) @(negedge clk);
        rd(8'h0F, d);
        check(d == 8'((rl - (cyc - c0)) >> 6), "R9 gauge later", d, (rl - (cyc - c0)) >> 6);
        wait_pulse(t);
        check(t - c0 == 12000, "R2 R10 1 ms frame", t - c0, 12000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule